// File: doc/BRIEF.md
# CPU-to-PCI Address Window Translator

This block sits between a processor bus and a PCI host bridge and turns one 32-bit address per request into a PCI-side region tag and a translated downstream address. Outbound (processor-issued) addresses are sorted into PCI I/O space, configuration space, the interrupt-acknowledge byte, PCI memory space or the boot ROM. Inbound (bus-master) addresses are sorted into PCI memory or system RAM. Any address outside these windows comes back tagged unmapped.

I/O space has two layouts, chosen by a level input. In the dense layout the I/O port is the low 16 bits of the window offset, giving a 64 KB space. In the sparse layout an 8 MB window is folded into 16 bits by keeping the low five bits and packing the 4 KB page number above them. Configuration accesses pick a device by the lowest set bit in a field of select bits. That bit's index becomes a device number beside the register field.

Requests arrive on a valid/ready channel. The translation is captured in a one-entry output register and held until the consumer takes it.

Top module: `pci_window_xlat`

## Requirements
- R1: An outbound address in [0x8000_0000, 0x8080_0000) with io_sparse_i = 0 yields region code 1 (I/O) and address = offset[15:0], where offset = address − 0x8000_0000.
- R2: The same I/O window with io_sparse_i = 1 yields region code 1 and address = {offset[22:12], offset[4:0]}, zero-extended to 32 bits.
- R3: An outbound address in [0x8080_0000, 0x80C0_0000) yields region code 2 (config) and address = {dev[4:0], offset[10:0]}, where offset = address − 0x8080_0000 and dev is the index (0..10) of the lowest set bit among offset bits 11..21, or 11 when none of them is set.
- R4: Outbound address 0xBFFF_FFF0 with size code 0 (one byte) yields region code 3 (interrupt acknowledge) and address 0. For a write, rsp_ignore_o is 1, and only there. Any other size code there yields region code 0.
- R5: An outbound address in [0xC000_0000, 0xFFF0_0000) yields region code 4 (PCI memory) and address = address − 0xC000_0000.
- R6: An outbound address in [0xFFF0_0000, 0xFFFF_FFFF] yields region code 5 (boot ROM) and address = address − 0xFFF0_0000.
- R7: With req_inbound_i = 1, an address below 0x3F00_0000 yields region code 4 at the same address, an address at or above 0x8000_0000 yields region code 6 (system RAM) at address − 0x8000_0000, and anything between yields region code 0.
- R8: Every other address, and every request with size code 3, yields region code 0 with address 0. Size codes 0, 1 and 2 are 1, 2 and 4 bytes, and need not be aligned.
- R9: io_sparse_i is sampled only in the cycle a request is accepted. Changing it afterwards does not change a result already captured.
- R10: A request accepted at a clock edge shows rsp_valid_o = 1 after that edge. The result and rsp_write_o stay stable while rsp_ready_i = 0. req_ready_o is 1 exactly when no result is held or the held result is being consumed.
- R11: After reset, rsp_valid_o is 0 and req_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_sparse_i | input | 1 | I/O layout select: 0 dense, 1 sparse |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted |
| req_addr_i | input | 32 | Address to translate |
| req_size_i | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3=invalid |
| req_write_i | input | 1 | Request is a write |
| req_inbound_i | input | 1 | 1 = bus-master address, 0 = processor address |
| rsp_valid_o | output | 1 | Result held |
| rsp_ready_i | input | 1 | Consumer takes the result |
| rsp_addr_o | output | 32 | Translated address |
| rsp_region_o | output | 3 | Region code |
| rsp_write_o | output | 1 | Write flag of the held request |
| rsp_ignore_o | output | 1 | Write that is accepted and discarded |

## Verification
The layout select and the request handshake can change in the same cycle. The bench toggles io_sparse_i on the same falling edge where it raises req_valid_i. It also flips the select while a captured sparse result is stalled by rsp_ready_i = 0, and checks that the held address keeps the layout from acceptance. In that same stall window the bench presents a second request. It checks that the second request is refused until the same edge that drains the first, and then that the second carries the select value current at its own acceptance.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_IO   = 3'd1,
    RGN_CFG  = 3'd2,
    RGN_IACK = 3'd3,
    RGN_MEM  = 3'd4,
    RGN_ROM  = 3'd5,
    RGN_RAM  = 3'd6
  } rgn_e;

  typedef struct packed {
    rgn_e        rgn;
    logic [31:0] addr;
    logic        write;
    logic        ignore;
  } xlat_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_BAD  = 2'd3;
endpackage

// File: rtl/pwx_cfg_encode.sv
module pwx_cfg_encode #(
  parameter int SEL_N = 11,
  parameter int DEV_W = 5
) (
  input  logic [SEL_N-1:0] sel_i,
  output logic [DEV_W-1:0] dev_o
);
  logic [SEL_N-1:0] first;

  // isolate lowest set select bit
  for (genvar g = 0; g < SEL_N; g++) begin : g_first
    if (g == 0) begin : g_lsb
      assign first[g] = sel_i[0];
    end else begin : g_up
      assign first[g] = sel_i[g] & ~(|sel_i[g-1:0]);
    end
  end

  logic [DEV_W-1:0] acc;
  always_comb begin
    acc = '0;
    for (int i = 0; i < SEL_N; i++) begin
      acc |= first[i] ? DEV_W'(i) : '0;
    end
    dev_o = (|sel_i) ? acc : DEV_W'(SEL_N);
  end

  always_comb begin
    AST_CFG_ONEHOT: assert ($onehot0(first)); // R3
  end
endmodule

// File: rtl/pwx_cpu_decode.sv
module pwx_cpu_decode
  import pwx_pkg::*;
#(
  parameter int              AW         = 32,
  parameter logic [AW-1:0]   IO_BASE    = 32'h8000_0000,
  parameter logic [AW-1:0]   IO_SPAN    = 32'h0080_0000,
  parameter int              IO_DENSE_W = 16,
  parameter int              SP_LO_W    = 5,
  parameter int              SP_PG_LSB  = 12,
  parameter logic [AW-1:0]   CFG_BASE   = 32'h8080_0000,
  parameter logic [AW-1:0]   CFG_SPAN   = 32'h0040_0000,
  parameter int              CFG_REG_W  = 11,
  parameter int              CFG_SEL_N  = 11,
  parameter int              DEV_W      = 5,
  parameter logic [AW-1:0]   IACK_ADDR  = 32'hBFFF_FFF0,
  parameter logic [AW-1:0]   MEM_BASE   = 32'hC000_0000,
  parameter logic [AW-1:0]   ROM_SIZE   = 32'h0010_0000
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          write_i,
  input  logic          sparse_i,
  output xlat_t         res_o
);
  localparam logic [AW-1:0] IO_END    = IO_BASE + IO_SPAN;
  localparam logic [AW-1:0] CFG_END   = CFG_BASE + CFG_SPAN;
  localparam logic [AW-1:0] ROM_BASE  = ~(ROM_SIZE - AW'(1));
  localparam int            IO_OFF_W  = $clog2(IO_SPAN);
  localparam int            CFG_OFF_W = CFG_REG_W + CFG_SEL_N;

  logic [IO_OFF_W-1:0]  io_off;
  logic [CFG_OFF_W-1:0] cfg_off;
  logic [DEV_W-1:0]     dev;
  logic [AW-1:0]        io_xlat;

  assign io_off  = IO_OFF_W'(addr_i - IO_BASE);
  assign cfg_off = CFG_OFF_W'(addr_i - CFG_BASE);

  pwx_cfg_encode #(
    .SEL_N (CFG_SEL_N),
    .DEV_W (DEV_W)
  ) u_cfg_encode (
    .sel_i (cfg_off[CFG_REG_W +: CFG_SEL_N]),
    .dev_o (dev)
  );

  always_comb begin
    if (sparse_i) io_xlat = AW'({io_off[IO_OFF_W-1:SP_PG_LSB], io_off[SP_LO_W-1:0]});
    else          io_xlat = AW'(io_off[IO_DENSE_W-1:0]);
  end

  always_comb begin
    res_o        = '0;
    res_o.rgn    = RGN_NONE;
    res_o.write  = write_i;
    if (size_i == SZ_BAD) begin
      res_o.rgn = RGN_NONE;
    end else if (addr_i >= ROM_BASE) begin
      res_o.rgn  = RGN_ROM;
      res_o.addr = addr_i - ROM_BASE;
    end else if (addr_i >= MEM_BASE) begin
      res_o.rgn  = RGN_MEM;
      res_o.addr = addr_i - MEM_BASE;
    end else if (addr_i == IACK_ADDR) begin
      // byte-only location; writes are swallowed
      if (size_i == SZ_BYTE) begin
        res_o.rgn    = RGN_IACK;
        res_o.ignore = write_i;
      end
    end else if (addr_i >= CFG_BASE && addr_i < CFG_END) begin
      res_o.rgn  = RGN_CFG;
      res_o.addr = AW'({dev, cfg_off[CFG_REG_W-1:0]});
    end else if (addr_i >= IO_BASE && addr_i < IO_END) begin
      res_o.rgn  = RGN_IO;
      res_o.addr = io_xlat;
    end
  end
endmodule

// File: rtl/pwx_inbound_map.sv
module pwx_inbound_map
  import pwx_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] PMEM_LIMIT = 32'h3F00_0000,
  parameter logic [AW-1:0] RAM_BASE   = 32'h8000_0000
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          write_i,
  output xlat_t         res_o
);
  always_comb begin
    res_o       = '0;
    res_o.rgn   = RGN_NONE;
    res_o.write = write_i;
    if (size_i != SZ_BAD) begin
      if (addr_i < PMEM_LIMIT) begin
        res_o.rgn  = RGN_MEM;
        res_o.addr = addr_i;
      end else if (addr_i >= RAM_BASE) begin
        res_o.rgn  = RGN_RAM;
        res_o.addr = addr_i - RAM_BASE;
      end
    end
  end
endmodule

// File: rtl/pwx_rsp_stage.sv
module pwx_rsp_stage
  import pwx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  in_valid_i,
  output logic  in_ready_o,
  input  xlat_t in_data_i,
  output logic  out_valid_o,
  input  logic  out_ready_i,
  output xlat_t out_data_o
);
  logic take;

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign take       = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      if (take) begin
        out_valid_o <= 1'b1;
        out_data_o  <= in_data_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)); // R10
  AST_ACCEPT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R10
endmodule

// File: rtl/pci_window_xlat.sv
module pci_window_xlat
  import pwx_pkg::*;
#(
  parameter int            AW         = 32,
  parameter logic [AW-1:0] IO_BASE    = 32'h8000_0000,
  parameter logic [AW-1:0] IO_SPAN    = 32'h0080_0000,
  parameter logic [AW-1:0] CFG_BASE   = 32'h8080_0000,
  parameter logic [AW-1:0] CFG_SPAN   = 32'h0040_0000,
  parameter logic [AW-1:0] IACK_ADDR  = 32'hBFFF_FFF0,
  parameter logic [AW-1:0] MEM_BASE   = 32'hC000_0000,
  parameter logic [AW-1:0] ROM_SIZE   = 32'h0010_0000,
  parameter logic [AW-1:0] PMEM_LIMIT = 32'h3F00_0000,
  parameter logic [AW-1:0] RAM_BASE   = 32'h8000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          io_sparse_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_write_i,
  input  logic          req_inbound_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [AW-1:0] rsp_addr_o,
  output logic [2:0]    rsp_region_o,
  output logic          rsp_write_o,
  output logic          rsp_ignore_o
);
  xlat_t cpu_res, inb_res, sel_res, held;

  pwx_cpu_decode #(
    .AW        (AW),
    .IO_BASE   (IO_BASE),
    .IO_SPAN   (IO_SPAN),
    .CFG_BASE  (CFG_BASE),
    .CFG_SPAN  (CFG_SPAN),
    .IACK_ADDR (IACK_ADDR),
    .MEM_BASE  (MEM_BASE),
    .ROM_SIZE  (ROM_SIZE)
  ) u_cpu_decode (
    .addr_i   (req_addr_i),
    .size_i   (req_size_i),
    .write_i  (req_write_i),
    .sparse_i (io_sparse_i),
    .res_o    (cpu_res)
  );

  pwx_inbound_map #(
    .AW         (AW),
    .PMEM_LIMIT (PMEM_LIMIT),
    .RAM_BASE   (RAM_BASE)
  ) u_inbound_map (
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .write_i (req_write_i),
    .res_o   (inb_res)
  );

  assign sel_res = req_inbound_i ? inb_res : cpu_res;

  pwx_rsp_stage u_rsp_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (sel_res),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .out_data_o  (held)
  );

  assign rsp_addr_o   = held.addr;
  assign rsp_region_o = held.rgn;
  assign rsp_write_o  = held.write;
  assign rsp_ignore_o = held.ignore;

  AST_NONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_region_o == RGN_NONE |-> rsp_addr_o == '0); // R8
  AST_ROM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_region_o == RGN_ROM |-> rsp_addr_o < ROM_SIZE); // R6
  AST_IACK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_region_o == RGN_IACK |-> rsp_addr_o == '0); // R4
  AST_IGNORE_IACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ignore_o |-> rsp_region_o == RGN_IACK && rsp_write_o); // R4
  AST_IO_16BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_region_o == RGN_IO |-> rsp_addr_o[AW-1:16] == '0); // R1
endmodule

// File: tb/pci_window_xlat_bench.sv
`timescale 1ns/1ps
module pci_window_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sparse = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_inb = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_region;
  logic        rsp_write;
  logic        rsp_ignore;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pci_window_xlat u_pci_window_xlat (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .io_sparse_i   (sparse),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready),
    .req_addr_i    (req_addr),
    .req_size_i    (req_size),
    .req_write_i   (req_write),
    .req_inbound_i (req_inb),
    .rsp_valid_o   (rsp_valid),
    .rsp_ready_i   (rsp_ready),
    .rsp_addr_o    (rsp_addr),
    .rsp_region_o  (rsp_region),
    .rsp_write_o   (rsp_write),
    .rsp_ignore_o  (rsp_ignore)
  );

  // {ignore, region[2:0], addr[31:0]}
  function automatic logic [35:0] model(logic [31:0] a, logic [1:0] sz, logic wr,
                                        logic inb, logic sp);
    logic [31:0] o;
    logic [4:0]  dev;
    if (sz == 2'd3) return '0;
    if (inb) begin
      if (a < 32'h3F00_0000) return {1'b0, 3'd4, a};
      if (a >= 32'h8000_0000) return {1'b0, 3'd6, a - 32'h8000_0000};
      return '0;
    end
    if (a >= 32'hFFF0_0000) return {1'b0, 3'd5, a - 32'hFFF0_0000};
    if (a >= 32'hC000_0000) return {1'b0, 3'd4, a - 32'hC000_0000};
    if (a == 32'hBFFF_FFF0) return (sz == 2'd0) ? {wr, 3'd3, 32'd0} : '0;
    if (a >= 32'h8080_0000 && a < 32'h80C0_0000) begin
      o = a - 32'h8080_0000;
      dev = 5'd11;
      for (int i = 10; i >= 0; i--) if (o[11+i]) dev = 5'(i);
      return {1'b0, 3'd2, 16'd0, dev, o[10:0]};
    end
    if (a >= 32'h8000_0000 && a < 32'h8080_0000) begin
      o = a - 32'h8000_0000;
      return sp ? {1'b0, 3'd1, 16'd0, o[22:12], o[4:0]} : {1'b0, 3'd1, 16'd0, o[15:0]};
    end
    return '0;
  endfunction

  task automatic check(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] got();
    return {rsp_ignore, rsp_region, rsp_addr};
  endfunction

  task automatic do_req(logic [31:0] a, logic [1:0] sz, logic wr, logic inb,
                        logic sp, string req);
    logic [35:0] exp;
    @(negedge clk);
    req_addr = a; req_size = sz; req_write = wr; req_inb = inb; sparse = sp;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    sparse = ~sp;
    exp = model(a, sz, wr, inb, sp);
    check(rsp_valid === 1'b1, {req, " valid"}, 36'(rsp_valid), 36'd1);
    check(got() === exp, req, got(), exp);
    check(rsp_write === wr, {req, " write"}, 36'(rsp_write), 36'(wr));
  endtask

  function automatic logic [31:0] rand_addr(int k);
    logic [31:0] r = $urandom;
    case (k)
      0: return 32'h8000_0000 + (r & 32'h007F_FFFF);
      1: return 32'h8080_0000 + (r & 32'h003F_FFFF);
      2: return 32'h8080_0000 + ((32'h1 << (11 + ($urandom % 11))) | (r & 32'h7FF));
      3: return 32'hC000_0000 + (r % 32'h3FF0_0000);
      4: return 32'hFFF0_0000 | (r & 32'h000F_FFFF);
      5: return 32'hBFFF_FFF0;
      default: return r;
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<100000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [35:0] e;
    void'($urandom(32'd20240611));
    #1;
    check(rsp_valid === 1'b0, "R11 rsp_valid in reset", 36'(rsp_valid), 36'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R11 rsp_valid after reset", 36'(rsp_valid), 36'd0);
    check(req_ready === 1'b1, "R11 req_ready after reset", 36'(req_ready), 36'd1);

    // directed corners
    do_req(32'h8000_1234, 2'd2, 1'b0, 1'b0, 1'b0, "R1 dense");
    do_req(32'h807F_FFFF, 2'd0, 1'b1, 1'b0, 1'b0, "R1 dense top");
    do_req(32'h807F_F01F, 2'd1, 1'b0, 1'b0, 1'b1, "R2 sparse pack");
    do_req(32'h8000_3003, 2'd2, 1'b0, 1'b0, 1'b1, "R2 sparse unaligned");
    do_req(32'h8080_0123, 2'd2, 1'b0, 1'b0, 1'b0, "R3 no select dev11");
    do_req(32'h80A0_07FF, 2'd0, 1'b0, 1'b0, 1'b0, "R3 bit21 dev10");
    do_req(32'h80A0_0800, 2'd0, 1'b0, 1'b0, 1'b0, "R3 bits11+21 dev0");
    do_req(32'hBFFF_FFF0, 2'd0, 1'b0, 1'b0, 1'b0, "R4 iack read");
    do_req(32'hBFFF_FFF0, 2'd0, 1'b1, 1'b0, 1'b0, "R4 iack write ignored");
    do_req(32'hBFFF_FFF0, 2'd1, 1'b0, 1'b0, 1'b0, "R4 iack wide");
    do_req(32'hC000_0000, 2'd2, 1'b0, 1'b0, 1'b0, "R5 mem base");
    do_req(32'hFFEF_FFFF, 2'd0, 1'b0, 1'b0, 1'b0, "R5 mem top");
    do_req(32'hFFF0_0000, 2'd2, 1'b0, 1'b0, 1'b0, "R6 rom base");
    do_req(32'hFFFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b0, "R6 rom top");
    do_req(32'h3EFF_FFFF, 2'd0, 1'b1, 1'b1, 1'b0, "R7 inbound pci mem");
    do_req(32'h3F00_0000, 2'd0, 1'b0, 1'b1, 1'b0, "R7 inbound hole");
    do_req(32'h8000_0000, 2'd2, 1'b0, 1'b1, 1'b0, "R7 inbound ram");
    do_req(32'h7FFF_FFFF, 2'd0, 1'b0, 1'b0, 1'b0, "R8 below io");
    do_req(32'h80C0_0000, 2'd0, 1'b0, 1'b0, 1'b0, "R8 above cfg");
    do_req(32'hBFFF_FFEF, 2'd0, 1'b0, 1'b0, 1'b0, "R8 near iack");
    do_req(32'hC000_0000, 2'd3, 1'b0, 1'b0, 1'b0, "R8 bad size");

    // R10: consumed with nothing new -> valid drops
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10 drain", 36'(rsp_valid), 36'd0);

    // R9/R10: stall a sparse result, flip the select, queue a second request
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 32'h8012_3456; req_size = 2'd1; req_write = 1'b0; req_inb = 1'b0;
    sparse = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    e = model(32'h8012_3456, 2'd1, 1'b0, 1'b0, 1'b1);
    sparse = 1'b0;
    req_addr = 32'h8000_ABCD; req_size = 2'd0; req_write = 1'b1;
    check(req_ready === 1'b0, "R10 refuse while stalled", 36'(req_ready), 36'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(got() === e, "R9 held sparse after select change", got(), e);
      check(rsp_write === 1'b0, "R10 write held", 36'(rsp_write), 36'd0);
      check(req_ready === 1'b0, "R10 still refused", 36'(req_ready), 36'd0);
    end
    rsp_ready = 1'b1;
    #0.1;
    check(req_ready === 1'b1, "R10 ready when draining", 36'(req_ready), 36'd1);
    @(negedge clk);
    req_valid = 1'b0;
    e = model(32'h8000_ABCD, 2'd0, 1'b1, 1'b0, 1'b0);
    check(rsp_valid === 1'b1, "R10 second valid", 36'(rsp_valid), 36'd1);
    check(got() === e, "R9 second uses own select", got(), e);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic inb;
      inb = ($urandom % 5) == 0;
      a = rand_addr(int'($urandom % 8));
      if (inb) begin
        case ($urandom % 2)
          0: do_req(a, 2'($urandom % 4), 1'($urandom), 1'b1, 1'($urandom), "R7 random inbound");
          default: do_req(a, 2'($urandom % 4), 1'($urandom), 1'b1, 1'($urandom), "R7 random inbound");
        endcase
      end else begin
        do_req(a, 2'($urandom % 4), 1'($urandom), 1'b0, 1'($urandom), "R1/R2/R3/R5/R6/R8 random outbound");
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule